// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

The block is a software-serviced watchdog with a 32-bit register interface. Software loads an interval into a timer-value register. It then keeps the system alive by writing, with any data, to the reload register. Each such write copies the interval into a down-counter. The counter steps down once per external tick, unless a halt bit is set. When the counter goes from 1 to 0, the first stage fires: a first-timeout status bit is raised and the counter starts a second interval.

If that second interval also runs out before the reload register is written again, the second stage fires. A sticky second-timeout bit is set, and a single-cycle system reset request is raised unless a no-reboot control bit is set. The second-timeout bit and the flag recording that the request has been sent are held in an always-on reset domain. They therefore survive the system reset that the request triggers, and the request is not sent again after that reset. Every other register is cleared by the system reset.

Registers sit at byte offsets 0x60 (reload and live count), 0x64 (status), 0x68 (control) and 0x70 (timer value). Reads are combinational. A write takes effect at the next clock edge.

Top module: `wdt_escalate`

## Requirements
- R1: While the system reset is asserted, the count reads 0, control reads 0 and timer value reads 0x40000. While the always-on reset is asserted, status reads 0. A counter at 0 neither steps nor expires on ticks.
- R2: A read of offset 0x60 returns the live count in bits 9:0, with bits 31:10 zero. Offset 0x70 returns the 19-bit timer value. Any other offset reads 0.
- R3: A write to 0x60 loads the counter from the timer value, whatever the write data. This load takes precedence over a tick in the same cycle, so no expiry occurs in that cycle.
- R4: Each tick decrements a non-zero counter by one while control bit 0 (halt) is 0. While halt is 1, the counter holds its value.
- R5: A tick that takes the counter from 1 to 0 is an expiry. If status bit 3 (first timeout) is clear, the expiry sets it and reloads the counter from the timer value.
- R6: An expiry with status bit 3 already set and no write to 0x60 since the previous expiry sets status bit 17 (second timeout). If a write to 0x60 came in between, bit 17 stays 0.
- R7: Writing 1 to status bit 3 or bit 17 clears that bit. Writing 0 leaves it unchanged. A set in the same cycle takes precedence over a clear.
- R8: Status bit 17 keeps its value through the system reset. Only the always-on reset or a write of 1 to bit 17 clears it.
- R9: sys_rst_req is a one-cycle pulse, raised in the cycle after bit 17 is set while control bit 1 (no-reboot) is 0. It is raised once per second-timeout event, and not again after a system reset.
- R10: While no-reboot is 1, no pulse is raised. Clearing no-reboot while bit 17 is still set raises the pulse in the cycle after the control write.
- R11: A status write that clears bit 17 in the cycle where the pulse would be decided suppresses that pulse.
- R12: Control bits other than bits 0 and 1 and timer-value bits above 18 ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| aon_rst_n | input | 1 | Always-on reset, active low, asynchronous |
| tick | input | 1 | Count enable, one decrement per cycle high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can fall in the same cycle. In the first, a reload write arrives with the tick that would take the counter from 1 to 0. The bench drives both together and expects the count to be back at the interval with no status bit set. In the second, a status write clears the second-timeout bit in the very cycle after that bit was set, when the reset request is being decided. The bench issues that write right after the expiring tick and expects status to keep only the first-timeout bit and no pulse to appear over the following cycles. The same kind of overlap is also driven between a status clear and an expiry that sets the first-timeout bit, where the set must win.

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
  parameter int TV_W    = 19,
  parameter int CNT_VIS = 10,
  parameter int ADDR_W  = 8,
  parameter int TV_RST  = 'h40000,
  parameter int OFS_RLD = 'h60,
  parameter int OFS_STS = 'h64,
  parameter int OFS_CTL = 'h68,
  parameter int OFS_TV  = 'h70,
  parameter int FIRST_BIT  = 3,
  parameter int SECOND_BIT = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aon_rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              sys_rst_req
);
  localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'(OFS_RLD);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_TV  = ADDR_W'(OFS_TV);
  localparam logic [TV_W-1:0]   ONE   = TV_W'(1);

  logic [TV_W-1:0] cnt, tv;
  logic halt, noreb;
  logic first_sts, second_sts, rld_seen, done;

  wire wr_rld = wr_en && addr == A_RLD;
  wire wr_sts = wr_en && addr == A_STS;
  wire wr_ctl = wr_en && addr == A_CTL;
  wire wr_tv  = wr_en && addr == A_TV;

  wire step   = tick && !halt && !wr_rld && cnt != '0;
  wire expire = step && cnt == ONE;
  wire esc    = expire && first_sts && !rld_seen;
  wire clr1   = wr_sts && wdata[FIRST_BIT];
  wire clr2   = wr_sts && wdata[SECOND_BIT];
  wire fire   = second_sts && !noreb && !done && !clr2;

  wire unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      tv          <= TV_W'(TV_RST);
      halt        <= 1'b0;
      noreb       <= 1'b0;
      first_sts   <= 1'b0;
      rld_seen    <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      if (wr_rld)      cnt <= tv;
      else if (expire) cnt <= tv;
      else if (step)   cnt <= cnt - ONE;

      if (wr_tv) tv <= wdata[TV_W-1:0];

      if (wr_ctl) begin
        halt  <= wdata[0];
        noreb <= wdata[1];
      end

      if (expire && !esc) first_sts <= 1'b1;
      else if (clr1)      first_sts <= 1'b0;

      if (wr_rld)      rld_seen <= 1'b1;
      else if (expire) rld_seen <= 1'b0;

      sys_rst_req <= fire;
    end
  end

  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) begin
      second_sts <= 1'b0;
      done       <= 1'b0;
    end else begin
      if (esc)       second_sts <= 1'b1;
      else if (clr2) second_sts <= 1'b0;

      if (clr2 && !esc) done <= 1'b0;
      else if (fire)    done <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_RLD: rdata[CNT_VIS-1:0] = cnt[CNT_VIS-1:0];
      A_STS: begin
        rdata[FIRST_BIT]  = first_sts;
        rdata[SECOND_BIT] = second_sts;
      end
      A_CTL: rdata[1:0] = {noreb, halt};
      A_TV:  rdata[TV_W-1:0] = tv;
      default: rdata = '0;
    endcase
  end
endmodule

module wdt_escalate_chk #(
  parameter int TV_W = 19,
  parameter int ADDR_W = 8,
  parameter int OFS_RLD = 'h60,
  parameter int OFS_STS = 'h64,
  parameter int SECOND_BIT = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aon_rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              sys_rst_req,
  input logic [TV_W-1:0]   cnt,
  input logic [TV_W-1:0]   tv,
  input logic              halt,
  input logic              noreb,
  input logic              first_sts,
  input logic              second_sts
);
  wire rldw = wr_en && addr == ADDR_W'(OFS_RLD);
  wire clrw = wr_en && addr == ADDR_W'(OFS_STS) && wdata[SECOND_BIT];
  wire unused_chk = ^wdata;

  a_r3_reload_loads: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    rldw |=> cnt == $past(tv));
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    (tick && !halt && !rldw && cnt > TV_W'(1)) |=> cnt == $past(cnt) - TV_W'(1));
  a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    (halt && !rldw) |=> $stable(cnt));
  a_r5_first_expiry: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    (tick && !halt && !rldw && cnt == TV_W'(1) && !first_sts) |=> (first_sts && cnt == $past(tv)));
  a_r8_second_sticky: assert property (@(posedge clk) disable iff (!aon_rst_n)
    (second_sts && !clrw) |=> second_sts);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    sys_rst_req |=> !sys_rst_req);
  a_r10_gated_request: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    sys_rst_req |-> (second_sts && !$past(noreb)));
endmodule

bind wdt_escalate wdt_escalate_chk #(
  .TV_W(TV_W), .ADDR_W(ADDR_W), .OFS_RLD(OFS_RLD), .OFS_STS(OFS_STS), .SECOND_BIT(SECOND_BIT)
) u_chk (.*);

// File: tb/wdt_escalate_bench.sv
module wdt_escalate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, aon_rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sys_rst_req;
  int checks = 0, fails = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  wdt_escalate u_wdt_escalate (.clk, .rst_n, .aon_rst_n, .tick, .wr_en,
                               .addr, .wdata, .rdata, .sys_rst_req);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pulses(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_req) p++;
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; aon_rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h60, v); chk("R1 count", v, 0);
    rd(8'h64, v); chk("R1 status", v, 0);
    rd(8'h68, v); chk("R1 control", v, 0);
    rd(8'h70, v); chk("R1 timer value", v, 32'h40000);
    tk(3);
    rd(8'h60, v); chk("R1 idle count", v, 0);
    rd(8'h64, v); chk("R1 idle status", v, 0);

    // R12 reserved bits, R2 unmapped
    wr(8'h68, 32'hFFFF_FFFF); rd(8'h68, v); chk("R12 control", v, 3);
    wr(8'h68, 0);
    wr(8'h70, 32'hFFFF_FFFF); rd(8'h70, v); chk("R12 timer value", v, 32'h7FFFF);
    rd(8'h6C, v); chk("R2 unmapped", v, 0);
    wr(8'h60, 0); rd(8'h60, v); chk("R2 count low bits", v, 32'h3FF);
    tk(1); rd(8'h60, v); chk("R2 count after step", v, 32'h3FE);

    // R3 R4 R5 R7 sweep over intervals
    for (int t = 1; t <= 8; t++) begin
      wr(8'h70, t);
      wr(8'h60, 32'hDEAD_BEEF);
      rd(8'h60, v); chk("R3 load", v, t);
      for (int k = 1; k < t; k++) begin
        tk(1); rd(8'h60, v); chk("R4 step", v, t - k);
      end
      tk(1);
      rd(8'h64, v); chk("R5 first set", v, 32'h8);
      rd(8'h60, v); chk("R5 restart", v, t);
      wr(8'h64, 32'h8);
      rd(8'h64, v); chk("R7 clear first", v, 0);
    end

    // R4 halt
    wr(8'h70, 5); wr(8'h60, 0);
    wr(8'h68, 1); tk(4); rd(8'h60, v); chk("R4 halted", v, 5);
    wr(8'h68, 0); tk(2); rd(8'h60, v); chk("R4 resumed", v, 3);

    // R3 reload against terminal tick
    wr(8'h70, 4); wr(8'h60, 0); tk(3);
    rd(8'h60, v); chk("R3 at one", v, 1);
    tick = 1'b1; wr(8'h60, 32'h5A5A); tick = 1'b0;
    rd(8'h60, v); chk("R3 reload wins", v, 4);
    rd(8'h64, v); chk("R3 no expiry", v, 0);

    // R7 set wins over clear, zero write no effect
    wr(8'h70, 2); wr(8'h60, 0); tk(1);
    tick = 1'b1; wr(8'h64, 32'hFFFF_FFFF); tick = 1'b0;
    rd(8'h64, v); chk("R7 set wins", v, 32'h8);
    wr(8'h64, 0); rd(8'h64, v); chk("R7 zero write", v, 32'h8);
    wr(8'h64, 32'h8); rd(8'h64, v); chk("R7 clear", v, 0);

    // R6 reload between expiries, then no reload
    wr(8'h68, 2);
    wr(8'h70, 3); wr(8'h60, 0); tk(3);
    rd(8'h64, v); chk("R6 first", v, 32'h8);
    wr(8'h60, 0); tk(3);
    rd(8'h64, v); chk("R6 reload between", v, 32'h8);
    tk(3);
    rd(8'h64, v); chk("R6 second", v, 32'h20008);

    // R10 suppression and release
    pulses(4, p); chk("R10 suppressed", p, 0);
    wr(8'h68, 0);
    chk("R10 not yet", sys_rst_req, 0);
    @(negedge clk); chk("R10 released pulse", sys_rst_req, 1);
    @(negedge clk); chk("R9 pulse width", sys_rst_req, 0);
    pulses(5, p); chk("R9 no repeat", p, 0);

    // R8 survives system reset
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(8'h64, v); chk("R8 sticky", v, 32'h20000);
    rd(8'h68, v); chk("R1 control after reset", v, 0);
    rd(8'h70, v); chk("R1 timer after reset", v, 32'h40000);
    rd(8'h60, v); chk("R1 count after reset", v, 0);
    pulses(5, p); chk("R9 none after reset", p, 0);
    wr(8'h64, 0); rd(8'h64, v); chk("R8 zero write", v, 32'h20000);
    wr(8'h64, 32'h20000); rd(8'h64, v); chk("R8 w1c", v, 0);

    // R9 immediate pulse with no-reboot clear
    wr(8'h70, 2); wr(8'h60, 0); tk(2); tk(2);
    chk("R9 not yet", sys_rst_req, 0);
    rd(8'h64, v); chk("R9 status", v, 32'h20008);
    @(negedge clk); chk("R9 pulse", sys_rst_req, 1);
    @(negedge clk); chk("R9 pulse ends", sys_rst_req, 0);

    // R11 clear in deciding cycle
    wr(8'h64, 32'h20008);
    wr(8'h60, 0); tk(2); tk(2);
    wr(8'h64, 32'h20000);
    pulses(5, p); chk("R11 suppressed", p, 0);
    rd(8'h64, v); chk("R11 status", v, 32'h8);

    // R1 always-on reset clears second timeout
    wr(8'h68, 2); tk(2);
    rd(8'h64, v); chk("R6 second again", v, 32'h20008);
    rst_n = 1'b0; aon_rst_n = 1'b0; repeat (2) @(negedge clk);
    rst_n = 1'b1; aon_rst_n = 1'b1;
    rd(8'h64, v); chk("R1 aon reset status", v, 0);

    finish_run();
  end
endmodule